// File: doc/BRIEF.md
# Panel Power and Backlight Sequencer

This block brings a flat-panel display up and down in a fixed order. On power-up it turns on the logic supply, then drives the interface signals, then lights the backlight lamp. On power-down it runs the same steps in reverse. A system-side controller holds `pwr_req` high for as long as it wants the panel on. A free-running millisecond strobe, `ms_tick`, times every step. The block watches a `supply_good` indication from the supply. If that indication does not arrive in time, the block shuts everything off and latches a fault.

Every minimum interval is a parameter counted in ticks:

| Parameter | Interval |
|---|---|
| `T_GOOD_MAX` | Longest wait for supply-good after the supply is enabled |
| `T_SUP_SIG` | Settle time from supply-good to signal enable |
| `T_SIG_LAMP` | Minimum time from signal enable to lamp on |
| `T_SUP_LAMP` | Minimum time from supply-good to lamp on |
| `T_LAMP_SIG` | Minimum time from lamp off to signal disable |
| `T_OFF_MIN` | Minimum supply-off time before the supply may be re-enabled |

The lamp waits for whichever of its two intervals ends later. A request that arrives while the supply is inside its minimum off window is not lost; the supply comes on as soon as the window closes.

How an interval is counted: it starts on the clock edge at which the corresponding output changes. A tick sampled on that same edge is not counted. The interval ends one clock after the tick that completes the count is sampled. All outputs are registered.

Top module: `pnl_pwr_seq`

## Requirements
- R1: While `rst_n` is low, `supply_en`, `sig_oe`, `lamp_en` and `fault` are all 0. The supply-off window counts from reset release, so the first `supply_en` rise happens no earlier than `T_OFF_MIN` ticks after reset.
- R2: With `pwr_req` high, the supply-off window elapsed and no fault latched, `supply_en` goes to 1.
- R3: If `supply_good` has not been seen high within `T_GOOD_MAX` ticks of `supply_en` rising, then on one edge `fault` rises and all three enables go to 0. `supply_good` arriving on the tick that ends that window still counts as in time. `fault` stays 1 and blocks any further power-up until reset.
- R4: `sig_oe` never rises before `supply_good` has been seen. It rises exactly `T_SUP_SIG` ticks after the edge at which `supply_good` is first sampled high.
- R5: `lamp_en` rises at the later of two points: `T_SIG_LAMP` ticks after `sig_oe` rose, and `T_SUP_LAMP` ticks after `supply_good` was first sampled high.
- R6: When `pwr_req` falls while the lamp is on, `lamp_en` falls first. Exactly `T_LAMP_SIG` ticks later, `sig_oe` and `supply_en` fall on the same edge.
- R7: When `pwr_req` falls before the lamp has come on, `sig_oe` and `supply_en` fall together on the next edge, and `lamp_en` does not rise.
- R8: After `supply_en` falls, it stays 0 for at least `T_OFF_MIN` ticks. A `pwr_req` held high through that window makes `supply_en` rise exactly `T_OFF_MIN` ticks after the fall.
- R9: `sig_oe` is never 1 while `supply_en` is 0, and `lamp_en` is never 1 while `sig_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock strobe marking each timing unit |
| pwr_req | input | 1 | Level request: 1 = panel on, 0 = panel off |
| supply_good | input | 1 | Supply has reached its good level |
| supply_en | output | 1 | Logic supply enable |
| sig_oe | output | 1 | Interface signal drive enable; 0 = outputs high impedance |
| lamp_en | output | 1 | Backlight lamp enable |
| fault | output | 1 | Sticky supply timeout flag, cleared only by reset |

## Verification
Timers that are loaded or decremented wrongly show up as interval errors at the enable pins. The tick count between one enable edge and the next moves by at least one unit on the very next sequence step. The bench measures each interval in ticks and compares it with the arithmetic expectation from the parameters.

A state machine stuck in, or skipping, a state shows up differently:
- An enable that never moves is caught within a single sequence.
- An enable out of order, such as the lamp without signals or signals without supply, is caught on the edge where it happens.

A fault flag that is lost or fails to latch is visible at the `fault` pin and at the absence of any re-power during the following off window.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    PS_OFF    = 3'd0,
    PS_RAMP   = 3'd1,
    PS_SETTLE = 3'd2,
    PS_SIG    = 3'd3,
    PS_LAMP   = 3'd4,
    PS_DIM    = 3'd5
  } pps_state_e;

  typedef enum logic [1:0] {
    STEP_GOOD   = 2'd0,
    STEP_SUPSIG = 2'd1,
    STEP_DIM    = 2'd2
  } pps_step_e;

endpackage

// File: rtl/pps_tick_timer.sv
module pps_tick_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load,
  input  logic         tick,
  output logic         done
);

  logic [W-1:0] cnt;

  // A load wins over a tick in the same cycle, so that tick is not counted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= W'(RST_VAL);
    end else if (start) begin
      cnt <= load;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

  // R8: without a fresh load the remaining interval only shrinks.
  a_r8_no_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_req,
  input  logic       supply_good,
  input  logic       step_done,
  input  logic       sup_lamp_done,
  input  logic       sig_lamp_done,
  input  logic       off_done,
  output pps_state_e state_q,
  output pps_state_e state_d,
  output logic       step_start,
  output pps_step_e  step_sel,
  output logic       sup_lamp_start,
  output logic       sig_lamp_start,
  output logic       off_start,
  output logic       fault
);

  logic fault_set;

  always_comb begin
    state_d        = state_q;
    step_start     = 1'b0;
    step_sel       = STEP_GOOD;
    sup_lamp_start = 1'b0;
    sig_lamp_start = 1'b0;
    off_start      = 1'b0;
    fault_set      = 1'b0;
    case (state_q)
      PS_OFF: begin
        if (pwr_req && off_done && !fault) begin
          state_d    = PS_RAMP;
          step_start = 1'b1;
          step_sel   = STEP_GOOD;
        end
      end
      PS_RAMP: begin
        if (!pwr_req) begin
          state_d   = PS_OFF;
          off_start = 1'b1;
        end else if (supply_good) begin
          state_d        = PS_SETTLE;
          step_start     = 1'b1;
          step_sel       = STEP_SUPSIG;
          sup_lamp_start = 1'b1;
        end else if (step_done) begin
          state_d   = PS_OFF;
          off_start = 1'b1;
          fault_set = 1'b1;
        end
      end
      PS_SETTLE: begin
        if (!pwr_req) begin
          state_d   = PS_OFF;
          off_start = 1'b1;
        end else if (step_done) begin
          state_d        = PS_SIG;
          sig_lamp_start = 1'b1;
        end
      end
      PS_SIG: begin
        if (!pwr_req) begin
          state_d   = PS_OFF;
          off_start = 1'b1;
        end else if (sup_lamp_done && sig_lamp_done) begin
          state_d = PS_LAMP;
        end
      end
      PS_LAMP: begin
        if (!pwr_req) begin
          state_d    = PS_DIM;
          step_start = 1'b1;
          step_sel   = STEP_DIM;
        end
      end
      PS_DIM: begin
        if (step_done) begin
          state_d   = PS_OFF;
          off_start = 1'b1;
        end
      end
      default: begin
        state_d   = PS_OFF;
        off_start = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
      fault   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (fault_set) begin
        fault <= 1'b1;
      end
    end
  end

  // R3: the latched fault keeps the machine parked in the off state.
  a_r3_fault_parks_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && state_q == PS_OFF) |=> (state_q == PS_OFF));

  // R4: leaving the supply ramp towards signal enable requires supply-good.
  a_r4_settle_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SETTLE && $past(state_q) == PS_RAMP) |-> $past(supply_good));

endmodule

// File: rtl/pnl_pwr_seq.sv
module pnl_pwr_seq
  import pps_pkg::*;
#(
  parameter int T_GOOD_MAX = 10,
  parameter int T_SUP_SIG  = 1,
  parameter int T_SIG_LAMP = 100,
  parameter int T_SUP_LAMP = 180,
  parameter int T_LAMP_SIG = 20,
  parameter int T_OFF_MIN  = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pwr_req,
  input  logic supply_good,
  output logic supply_en,
  output logic sig_oe,
  output logic lamp_en,
  output logic fault
);

  localparam int MAX_A = (T_GOOD_MAX > T_SUP_SIG)  ? T_GOOD_MAX : T_SUP_SIG;
  localparam int MAX_B = (T_SIG_LAMP > T_SUP_LAMP) ? T_SIG_LAMP : T_SUP_LAMP;
  localparam int MAX_C = (T_LAMP_SIG > T_OFF_MIN)  ? T_LAMP_SIG : T_OFF_MIN;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T = (MAX_C > MAX_D) ? MAX_C : MAX_D;
  localparam int TW    = $clog2(MAX_T + 1);

  pps_state_e    state_q, state_d;
  pps_step_e     step_sel;
  logic          step_start, sup_lamp_start, sig_lamp_start, off_start;
  logic          step_done, sup_lamp_done, sig_lamp_done, off_done;
  logic [TW-1:0] step_load;

  pps_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwr_req        (pwr_req),
    .supply_good    (supply_good),
    .step_done      (step_done),
    .sup_lamp_done  (sup_lamp_done),
    .sig_lamp_done  (sig_lamp_done),
    .off_done       (off_done),
    .state_q        (state_q),
    .state_d        (state_d),
    .step_start     (step_start),
    .step_sel       (step_sel),
    .sup_lamp_start (sup_lamp_start),
    .sig_lamp_start (sig_lamp_start),
    .off_start      (off_start),
    .fault          (fault)
  );

  always_comb begin
    case (step_sel)
      STEP_SUPSIG: step_load = TW'(T_SUP_SIG);
      STEP_DIM:    step_load = TW'(T_LAMP_SIG);
      default:     step_load = TW'(T_GOOD_MAX);
    endcase
  end

  pps_tick_timer #(.W(TW), .RST_VAL(0)) u_step (
    .clk(clk), .rst_n(rst_n), .start(step_start), .load(step_load),
    .tick(ms_tick), .done(step_done));

  pps_tick_timer #(.W(TW), .RST_VAL(0)) u_sup_lamp (
    .clk(clk), .rst_n(rst_n), .start(sup_lamp_start), .load(TW'(T_SUP_LAMP)),
    .tick(ms_tick), .done(sup_lamp_done));

  pps_tick_timer #(.W(TW), .RST_VAL(0)) u_sig_lamp (
    .clk(clk), .rst_n(rst_n), .start(sig_lamp_start), .load(TW'(T_SIG_LAMP)),
    .tick(ms_tick), .done(sig_lamp_done));

  // The off window is already running when reset releases.
  pps_tick_timer #(.W(TW), .RST_VAL(T_OFF_MIN)) u_off (
    .clk(clk), .rst_n(rst_n), .start(off_start), .load(TW'(T_OFF_MIN)),
    .tick(ms_tick), .done(off_done));

  // Enables are registered from the next state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supply_en <= 1'b0;
      sig_oe    <= 1'b0;
      lamp_en   <= 1'b0;
    end else begin
      supply_en <= (state_d != PS_OFF);
      sig_oe    <= (state_d == PS_SIG) || (state_d == PS_LAMP) || (state_d == PS_DIM);
      lamp_en   <= (state_d == PS_LAMP);
    end
  end

  a_r9_sig_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    sig_oe |-> supply_en);

  a_r9_lamp_needs_sig: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_en |-> sig_oe);

  a_r2_rise_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_en) |-> ($past(off_done) && !$past(fault)));

  a_r5_lamp_after_both: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamp_en) |-> ($past(sup_lamp_done) && $past(sig_lamp_done)));

  a_r6_dim_before_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sig_oe) && $past(state_q) == PS_DIM) |-> $past(step_done));

  a_r3_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  a_r3_fault_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (!supply_en && !sig_oe && !lamp_en));

endmodule

// File: tb/pnl_pwr_seq_test.sv
module pnl_pwr_seq_test;

  localparam int GOOD_MAX = 4;
  localparam int SUP_SIG  = 2;
  localparam int SIG_LAMP = 5;
  localparam int LAMP_SIG = 3;
  localparam int OFF_MIN  = 6;
  localparam int TICK_P   = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ms_tick;
  logic       pwr_req;
  logic [1:0] good;
  logic [1:0] sup_en, sig_oe, lamp_en, fault;

  int ticks;
  int good_dly;
  int checks = 0;
  int errors = 0;
  int t_sup_r[2], t_sup_f[2], t_sig_r[2], t_sig_f[2];
  int t_lamp_r[2], t_lamp_f[2], t_fault_r[2], viol[2], lamp_rises[2];

  always #5 clk = ~clk;

  // Instance 0: the signal-to-lamp interval dominates. Instance 1: supply-to-lamp dominates.
  function automatic int sup_lamp(input int i);
    return (i == 0) ? 6 : 12;
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_dut
    pnl_pwr_seq #(
      .T_GOOD_MAX(GOOD_MAX), .T_SUP_SIG(SUP_SIG), .T_SIG_LAMP(SIG_LAMP),
      .T_SUP_LAMP((g == 0) ? 6 : 12), .T_LAMP_SIG(LAMP_SIG), .T_OFF_MIN(OFF_MIN)
    ) uut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_req(pwr_req),
      .supply_good(good[g]), .supply_en(sup_en[g]), .sig_oe(sig_oe[g]),
      .lamp_en(lamp_en[g]), .fault(fault[g]));
  end

  always @(posedge clk) begin
    if (!rst_n) ticks <= 0;
    else if (ms_tick) ticks <= ticks + 1;
  end

  initial begin
    ms_tick = 1'b0;
    forever begin
      repeat (TICK_P - 1) @(negedge clk);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  // Edge recorder plus supply model: supply_good comes good_dly ticks after enable.
  initial begin
    logic [1:0] p_sup, p_sig, p_lamp, p_fault;
    p_sup = '0; p_sig = '0; p_lamp = '0; p_fault = '0; good = '0;
    for (int i = 0; i < 2; i++) begin
      t_sup_r[i] = 0; t_sup_f[i] = 0; t_sig_r[i] = 0; t_sig_f[i] = 0;
      t_lamp_r[i] = 0; t_lamp_f[i] = 0; t_fault_r[i] = 0; viol[i] = 0; lamp_rises[i] = 0;
    end
    forever begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        if (sup_en[i] && !p_sup[i]) t_sup_r[i] = ticks;
        if (!sup_en[i] && p_sup[i]) t_sup_f[i] = ticks;
        if (sig_oe[i] && !p_sig[i]) t_sig_r[i] = ticks;
        if (!sig_oe[i] && p_sig[i]) t_sig_f[i] = ticks;
        if (lamp_en[i] && !p_lamp[i]) begin t_lamp_r[i] = ticks; lamp_rises[i]++; end
        if (!lamp_en[i] && p_lamp[i]) t_lamp_f[i] = ticks;
        if (fault[i] && !p_fault[i]) t_fault_r[i] = ticks;
        if ((sig_oe[i] && !sup_en[i]) || (lamp_en[i] && !sig_oe[i])) viol[i]++;
        good[i] = sup_en[i] && ((ticks - t_sup_r[i]) >= good_dly);
      end
      p_sup = sup_en; p_sig = sig_oe; p_lamp = lamp_en; p_fault = fault;
    end
  end

  task automatic chk(input string req, input int i, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s inst%0d: actual %0d expected %0d", req, i, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_all_sup(input logic lvl);
    for (int n = 0; n < 3000 && !(sup_en == {2{lvl}}); n++) settle();
  endtask

  task automatic power_up(input int d);
    good_dly = d;
    pwr_req  = 1'b1;
    wait_all_sup(1'b1);
    for (int n = 0; n < 3000 && !(&lamp_en); n++) settle();
    for (int i = 0; i < 2; i++) begin
      int sg;
      int lamp_exp;
      sg = t_sup_r[i] + d;
      // R8: held request acts exactly when the off window ends (R1 for the first one).
      chk("R8", i, t_sup_r[i] - t_sup_f[i], OFF_MIN);
      chk("R2", i, int'(sup_en[i]), 1);
      chk("R4", i, t_sig_r[i], sg + SUP_SIG);
      lamp_exp = (t_sig_r[i] + SIG_LAMP > sg + sup_lamp(i)) ?
                 t_sig_r[i] + SIG_LAMP : sg + sup_lamp(i);
      chk("R5", i, t_lamp_r[i], lamp_exp);
    end
  endtask

  task automatic power_down();
    pwr_req = 1'b0;
    wait_all_sup(1'b0);
    for (int i = 0; i < 2; i++) begin
      chk("R6", i, t_sig_f[i] - t_lamp_f[i], LAMP_SIG);
      chk("R6", i, t_sup_f[i], t_sig_f[i]);
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    pwr_req  = 1'b0;
    good_dly = 1;
    repeat (5) settle();
    for (int i = 0; i < 2; i++) begin
      chk("R1", i, int'({sup_en[i], sig_oe[i], lamp_en[i], fault[i]}), 0);
    end
    pwr_req = 1'b1;
    settle();
    rst_n = 1'b1;

    // Sweep supply-good delay across the whole allowed window, up to the timeout boundary.
    for (int d = 1; d <= GOOD_MAX; d++) begin
      power_up(d);
      power_down();
    end

    // R7: request removed after signals come up but before the lamp.
    good_dly = 1;
    pwr_req  = 1'b1;
    for (int n = 0; n < 3000 && !(&sig_oe); n++) settle();
    begin
      int lr0, lr1;
      lr0 = lamp_rises[0];
      lr1 = lamp_rises[1];
      pwr_req = 1'b0;
      wait_all_sup(1'b0);
      for (int i = 0; i < 2; i++) begin
        chk("R7", i, t_sup_f[i], t_sig_f[i]);
        chk("R7", i, lamp_rises[i], (i == 0) ? lr0 : lr1);
      end
    end

    // R3: supply never becomes good.
    good_dly = 1000;
    pwr_req  = 1'b1;
    for (int n = 0; n < 3000 && !(&fault); n++) settle();
    for (int i = 0; i < 2; i++) begin
      chk("R3", i, t_fault_r[i] - t_sup_r[i], GOOD_MAX);
      chk("R3", i, t_sup_f[i], t_fault_r[i]);
      chk("R3", i, int'({sup_en[i], sig_oe[i], lamp_en[i]}), 0);
    end
    repeat ((OFF_MIN + 4) * TICK_P) settle();
    for (int i = 0; i < 2; i++) begin
      chk("R3", i, int'({sup_en[i], fault[i]}), 1);
    end

    rst_n = 1'b0;
    repeat (3) settle();
    for (int i = 0; i < 2; i++) begin
      chk("R1", i, int'(fault[i]), 0);
      chk("R9", i, viol[i], 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule